// File: doc/BRIEF.md
# Camera Control Register Slave

This block is the control-side endpoint of an image sensor. It answers on a two-wire serial bus (one clock line, one open-drain data line) and owns a bank of 256 eight-bit configuration registers that the rest of the sensor reads. A bus master addresses it with a seven-bit device identifier. The identifier is either a fixed value or is partly built from three strap inputs, which are captured while reset is applied. A write transfer carries the identifier, a register index and one or more data bytes. A read transfer first writes the index, then restarts the bus and reads data bytes back. The index advances by one after every data byte.

Both bus lines pass through a two-stage synchroniser and a run-length glitch filter before start and stop conditions are decoded. The slave acknowledges by enabling a low driver on the data line. Setting the top bit of register 12h has the same effect as a hardware reset: the whole register bank clears, the straps are captured again, and a core reset output is raised for a fixed number of cycles. A power-down input holds the bus logic in reset and leaves every register value untouched.

Top module: `cam_ctrl_slave`

## Requirements
- R1: With the ID-select strap latched low, the slave answers only to write byte 42h and read byte 43h, whatever the three identifier straps say.
- R2: With the ID-select strap latched high, the address byte is 0,1,0,S2,S1,S0,1,R/W (MSB first, S2..S0 = strap_id[2:0] as captured during reset); strap changes after reset have no effect.
- R3: After an address byte that does not match, the slave gives no acknowledge and ignores every byte until the next start condition.
- R4: The slave drives the data line low during the ninth clock after a matching address byte, after the index byte and after each write data byte.
- R5: A write transfer (address, index, data) stores the data byte in the register selected by the index.
- R6: The index increments after each data byte of a transfer, in both directions, and wraps from FFh to 00h.
- R7: In a read transfer the slave shifts out the indexed register MSB first and releases the data line in the ninth clock; a master acknowledge continues with the next index, a master not-acknowledge ends the transfer.
- R8: Start and stop are data-line edges while the clock is high after filtering; pulses on either line shorter than FILT_LEN clock cycles are ignored.
- R9: While rst_hw is high, every register reads back as 00h, sda_oe_o is low and core_rst_o is high.
- R10: Writing a byte with bit 7 set to register 12h clears every register (so the bit reads back 0), recaptures the straps, and holds core_rst_o high for exactly RST_HOLD_CYC cycles.
- R11: While pwdn is high, core_rst_o is high, the data line is released and bus traffic is ignored; register contents are unchanged afterwards.
- R12: A stop condition at any point returns the slave to idle, so clocked bytes without a new start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples both bus lines |
| rst_hw | input | 1 | High-active hardware reset, also captures the straps |
| pwdn | input | 1 | Power-down, resets bus logic but keeps registers |
| multi_id_en | input | 1 | ID-select strap: 1 uses strap_id, 0 uses the fixed identifier |
| strap_id | input | 3 | Identifier straps, captured in reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | When 1, pull the data line low |
| core_rst_o | output | 1 | Reset for the rest of the sensor (hardware, soft or power-down) |

## Verification
Register traffic is driven as random bursts of one to four bytes at random indexes, mixed with directed cases. Matching and non-matching identifiers under both ID-select settings separate the fixed identifier from the strap-built one and from straps changed after reset. Bursts that cross FFh separate the wrapping index from a saturating one. Single-cycle pulses injected on both lines inside a write test whether the filter lets through false clock edges or false start/stop conditions. Power-down, stop-then-raw-byte and a soft reset write, each followed by read-back, tell which state survives and which is cleared.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [6:0] FIXED_ID = 7'h21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RXID, ST_RXSUB, ST_RXDAT, ST_ACK, ST_TX, ST_MACK
  } bus_state_e;

  // Seven-bit identifier: fixed, or 0 1 0 s2 s1 s0 1 built from straps.
  function automatic logic [6:0] dev_id(input logic multi, input logic [2:0] strap);
    return multi ? {3'b010, strap, 1'b1} : FIXED_ID;
  endfunction
endpackage

// File: rtl/ccs_deglitch.sv
module ccs_deglitch #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // Output follows the synchronised input only after FILT_LEN agreeing cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {2{RST_VAL}};
      run_q  <= '0;
      dout   <= RST_VAL;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assert_filter_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dout) |-> $past(sync_q[1]))
    else $error("filtered line rose without a high synchronised input");
  assert_filter_fall_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(dout) |-> !$past(sync_q[1]))
    else $error("filtered line fell without a low synchronised input");
endmodule

// File: rtl/ccs_regfile.sv
module ccs_regfile #(
  parameter int REG_COUNT = 256,
  parameter int SRST_ADDR = 8'h12,
  parameter int SRST_BIT  = 7,
  localparam int ADDR_W   = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              soft_hit
);
  localparam logic [ADDR_W-1:0] SRST_IDX = ADDR_W'(SRST_ADDR);

  logic [7:0] mem [REG_COUNT];

  assign soft_hit = wr_en && (addr == SRST_IDX) && wr_data[SRST_BIT];
  assign rd_data  = mem[addr];

  always_ff @(posedge clk) begin
    if (rst || soft_hit) begin
      for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assert_soft_self_clear_R10: assert property (@(posedge clk) disable iff (rst)
    soft_hit |=> (mem[SRST_IDX] == 8'h00))
    else $error("soft reset bit did not clear itself");
  assert_reset_clears_R9: assert property (@(posedge clk)
    $fell(rst) |-> (rd_data == 8'h00))
    else $error("register not cleared by hardware reset");
  assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (addr != $past(addr)) || (rd_data == $past(rd_data)))
    else $error("register changed without a write");
endmodule

// File: rtl/ccs_bus_engine.sv
module ccs_bus_engine
  import ccs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda,
  input  logic [6:0]        my_id,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic              sda_oe
);
  bus_state_e        st_q, after_q;
  logic              scl_p, sda_p, nack_q;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg_q, tx_q;
  logic [ADDR_W-1:0] sub_q;

  // Named bus events, used by the state machine and the assertions.
  logic scl_rise, scl_fall, start_evt, stop_evt, byte_done, id_hit, id_miss;
  assign scl_rise  = scl & ~scl_p;
  assign scl_fall  = ~scl & scl_p;
  assign start_evt = scl & scl_p & sda_p & ~sda;
  assign stop_evt  = scl & scl_p & ~sda_p & sda;
  assign byte_done = scl_fall && (bit_cnt == 4'd8) && !start_evt && !stop_evt;
  assign id_hit    = byte_done && (st_q == ST_RXID) && (shreg_q[7:1] == my_id);
  assign id_miss   = byte_done && (st_q == ST_RXID) && (shreg_q[7:1] != my_id);
  assign wr_en     = byte_done && (st_q == ST_RXDAT);
  assign wr_data   = shreg_q;
  assign reg_addr  = sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      after_q <= ST_IDLE;
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
      nack_q  <= 1'b1;
      bit_cnt <= '0;
      shreg_q <= '0;
      tx_q    <= '0;
      sub_q   <= '0;
      sda_oe  <= 1'b0;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
      if (start_evt) begin
        st_q    <= ST_RXID;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        st_q   <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st_q)
          ST_RXID, ST_RXSUB, ST_RXDAT: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              if (id_miss) begin
                st_q <= ST_IDLE;
              end else begin
                st_q   <= ST_ACK;
                sda_oe <= 1'b1;
                if (st_q == ST_RXID) begin
                  after_q <= shreg_q[0] ? ST_TX : ST_RXSUB;
                end else if (st_q == ST_RXSUB) begin
                  sub_q   <= shreg_q[ADDR_W-1:0];
                  after_q <= ST_RXDAT;
                end else begin
                  sub_q   <= sub_q + 1'b1;
                  after_q <= ST_RXDAT;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              st_q    <= after_q;
              bit_cnt <= '0;
              if (after_q == ST_TX) begin
                tx_q   <= rd_data;
                sub_q  <= sub_q + 1'b1;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                st_q   <= ST_MACK;
                sda_oe <= 1'b0;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              nack_q <= sda;
            end else if (scl_fall) begin
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                st_q    <= ST_TX;
                bit_cnt <= '0;
                tx_q    <= rd_data;
                sub_q   <= sub_q + 1'b1;
                sda_oe  <= ~rd_data[BYTE_W-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_id_ack_R2: assert property (@(posedge clk) disable iff (rst)
    id_hit |=> sda_oe)
    else $error("matching identifier not acknowledged");
  assert_id_no_ack_R3: assert property (@(posedge clk) disable iff (rst)
    id_miss |=> !sda_oe)
    else $error("foreign identifier acknowledged");
  assert_write_ack_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> sda_oe)
    else $error("write data byte not acknowledged");
  assert_start_enters_id_R8: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (st_q == ST_RXID) && !sda_oe)
    else $error("start condition not taken");
  assert_master_nack_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_MACK) && scl_fall && nack_q && !start_evt && !stop_evt |=> !sda_oe && (st_q == ST_IDLE))
    else $error("read not ended by master not-acknowledge");
  assert_stop_idle_R12: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (st_q == ST_IDLE) && !sda_oe)
    else $error("stop condition did not release the bus");
endmodule

// File: rtl/cam_ctrl_slave.sv
module cam_ctrl_slave
  import ccs_pkg::*;
#(
  parameter int REG_COUNT    = 256,
  parameter int FILT_LEN     = 3,
  parameter int RST_HOLD_CYC = 16,
  parameter int SRST_ADDR    = 8'h12,
  parameter int SRST_BIT     = 7
) (
  input  logic       clk,
  input  logic       rst_hw,
  input  logic       pwdn,
  input  logic       multi_id_en,
  input  logic [2:0] strap_id,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       core_rst_o
);
  localparam int ADDR_W = $clog2(REG_COUNT);
  localparam int HW     = $clog2(RST_HOLD_CYC + 1);

  logic              line_rst, soft_hit, wr_en, multi_q;
  logic [2:0]        strap_q;
  logic [6:0]        my_id;
  logic [1:0]        raw_lines, clean_lines;
  logic [ADDR_W-1:0] reg_addr;
  logic [7:0]        wr_data, rd_data;
  logic [HW-1:0]     hold_q;

  // Bus logic is reset by hardware reset and by power-down; registers only by reset.
  assign line_rst  = rst_hw | pwdn;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    ccs_deglitch #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_dg (
      .clk  (clk),
      .rst  (line_rst),
      .din  (raw_lines[g]),
      .dout (clean_lines[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst_hw || soft_hit) begin
      strap_q <= strap_id;
      multi_q <= multi_id_en;
    end
  end

  assign my_id = dev_id(multi_q, strap_q);

  ccs_bus_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk      (clk),
    .rst      (line_rst),
    .scl      (clean_lines[0]),
    .sda      (clean_lines[1]),
    .my_id    (my_id),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe_o)
  );

  ccs_regfile #(.REG_COUNT(REG_COUNT), .SRST_ADDR(SRST_ADDR), .SRST_BIT(SRST_BIT)) u_regs (
    .clk      (clk),
    .rst      (rst_hw),
    .wr_en    (wr_en),
    .addr     (reg_addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .soft_hit (soft_hit)
  );

  // Soft reset stretch: exactly RST_HOLD_CYC cycles after the triggering write.
  always_ff @(posedge clk) begin
    if (rst_hw)              hold_q <= '0;
    else if (soft_hit)       hold_q <= HW'(RST_HOLD_CYC);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign core_rst_o = rst_hw | pwdn | (hold_q != '0);

  assert_soft_pulse_R10: assert property (@(posedge clk) disable iff (rst_hw)
    soft_hit |=> core_rst_o)
    else $error("soft reset did not raise core reset");
  assert_pwdn_release_R11: assert property (@(posedge clk) disable iff (rst_hw)
    pwdn |=> !sda_oe_o)
    else $error("data line driven during power-down");
endmodule

// File: tb/sim_cam_ctrl_slave.sv
module sim_cam_ctrl_slave;
  localparam int HOLD = 16;
  localparam int Q    = 12;

  logic       clk = 1'b0;
  logic       rst_hw = 1'b1, pwdn = 1'b0, multi_id_en = 1'b0;
  logic [2:0] strap_id = 3'd5;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe_o, core_rst_o, sda_line;

  assign sda_line = sda_m & ~sda_oe_o;
  always #2 clk = ~clk;

  cam_ctrl_slave #(.RST_HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_hw(rst_hw), .pwdn(pwdn), .multi_id_en(multi_id_en),
    .strap_id(strap_id), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .core_rst_o(core_rst_o)
  );

  int tests = 0, fails = 0, srst_cnt = 0;
  bit done = 1'b0, glitch_en = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always @(negedge clk) if (core_rst_o && !rst_hw && !pwdn) srst_cnt++;

  // Address byte restated from the bit layout 0 1 0 s2 s1 s0 1 rw.
  function automatic logic [7:0] id_byte(input logic multi, input logic [2:0] s);
    return multi ? (8'h42 | {3'b000, s, 2'b00}) : 8'h42;
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      if (glitch_en) begin scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(1); end
      scl_m = 1'b1; tick(Q);
      if (glitch_en) begin sda_m = ~b[i]; tick(1); sda_m = b[i]; end
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(2); sda_m = mack ? 1'b0 : 1'b1; tick(Q - 2);
    scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(2); sda_m = 1'b1; tick(Q - 2);
  endtask

  task automatic do_write(input logic [7:0] idb, input logic [7:0] sub, input int n, output int acks);
    bit a;
    acks = 0;
    bus_start();
    send_byte(idb, a); acks += int'(a);
    send_byte(sub, a); acks += int'(a);
    for (int k = 0; k < n; k++) begin send_byte(wbuf[k], a); acks += int'(a); end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] idb, input logic [7:0] sub, input int n, output int acks);
    bit a;
    logic [7:0] b;
    acks = 0;
    bus_start();
    send_byte(idb & 8'hFE, a); acks += int'(a);
    send_byte(sub, a); acks += int'(a);
    bus_start();
    send_byte(idb | 8'h01, a); acks += int'(a);
    for (int k = 0; k < n; k++) begin recv_byte(k < n - 1, b); rbuf[k] = b; end
    bus_stop();
  endtask

  task automatic model_write(input logic [7:0] sub, input int n);
    for (int k = 0; k < n; k++) exp_mem[8'(sub + k)] = wbuf[k];
  endtask

  task automatic model_clear();
    for (int k = 0; k < 256; k++) exp_mem[k] = 8'h00;
  endtask

  task automatic hw_reset(input logic m, input logic [2:0] s);
    rst_hw = 1'b1; multi_id_en = m; strap_id = s;
    tick(10);
    chk(sda_oe_o == 1'b0, "R9 sda released in reset", int'(sda_oe_o), 0);
    chk(core_rst_o == 1'b1, "R9 core reset in reset", int'(core_rst_o), 1);
    rst_hw = 1'b0; model_clear(); tick(4);
    chk(core_rst_o == 1'b0, "R9 core reset released", int'(core_rst_o), 0);
  endtask

  task automatic read_cmp(input logic [7:0] idb, input logic [7:0] sub, input int n, input string req);
    int acks;
    do_read(idb, sub, n, acks);
    chk(acks == 3, req, acks, 3);
    for (int k = 0; k < n; k++)
      chk(rbuf[k] == exp_mem[8'(sub + k)], req, int'(rbuf[k]), int'(exp_mem[8'(sub + k)]));
  endtask

  initial begin
    int acks, base, n;
    logic [7:0] s, idw;
    bit a;
    void'($urandom(32'd715));
    model_clear();

    // Fixed identifier, straps ignored
    hw_reset(1'b0, 3'd5);
    read_cmp(8'h42, 8'h00, 4, "R1 fixed id read after reset R9");
    wbuf[0] = 8'h5A;
    do_write(8'h56, 8'h01, 1, acks);
    chk(acks == 0, "R1 strap id ignored, R3 no ack", acks, 0);
    read_cmp(8'h42, 8'h01, 1, "R3 ignored write left register");

    // Strap-built identifier
    hw_reset(1'b1, 3'd5);
    idw = id_byte(1'b1, 3'd5);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(idw, 8'h10, 3, acks);
    chk(acks == 5, "R4 R5 acks on write", acks, 5);
    model_write(8'h10, 3);
    read_cmp(idw, 8'h10, 3, "R2 R6 R7 burst read back");
    do_write(8'h42, 8'h10, 1, acks);
    chk(acks == 0, "R2 fixed id unused when strap mode", acks, 0);
    strap_id = 3'd3;
    do_write(id_byte(1'b1, 3'd3), 8'h10, 1, acks);
    chk(acks == 0, "R2 strap change after reset ignored", acks, 0);

    // Random bursts
    for (int it = 0; it < 14; it++) begin
      n = 1 + int'($urandom % 4);
      s = 8'($urandom);
      if ($urandom % 2 == 0) begin
        for (int k = 0; k < n; k++) begin
          wbuf[k] = 8'($urandom);
          if (8'(s + k) == 8'h12) wbuf[k][7] = 1'b0;
        end
        do_write(idw, s, n, acks);
        chk(acks == n + 2, "R4 R5 random write acks", acks, n + 2);
        model_write(s, n);
      end else begin
        read_cmp(idw, s, n, "R6 R7 random read");
      end
    end

    // Index wrap
    wbuf[0] = 8'hE1; wbuf[1] = 8'h1E;
    do_write(idw, 8'hFF, 2, acks);
    model_write(8'hFF, 2);
    read_cmp(idw, 8'hFF, 2, "R6 index wrap");

    // Short pulses on both lines inside a write
    glitch_en = 1'b1;
    wbuf[0] = 8'hA5;
    do_write(idw, 8'h20, 1, acks);
    glitch_en = 1'b0;
    chk(acks == 3, "R8 glitched write acks", acks, 3);
    model_write(8'h20, 1);
    read_cmp(idw, 8'h20, 1, "R8 glitched write data");

    // Stop then a byte without start
    bus_start(); send_byte(idw, a); send_byte(8'h30, a); bus_stop();
    send_byte(8'h77, a);
    chk(a == 1'b0, "R12 byte after stop not acked", int'(a), 0);
    bus_stop();
    read_cmp(idw, 8'h30, 1, "R12 register unchanged after stop");

    // Power-down
    pwdn = 1'b1; tick(20);
    chk(core_rst_o == 1'b1, "R11 core reset in power-down", int'(core_rst_o), 1);
    wbuf[0] = 8'h99;
    do_write(idw, 8'h10, 1, acks);
    chk(acks == 0, "R11 bus ignored in power-down", acks, 0);
    chk(sda_oe_o == 1'b0, "R11 line released", int'(sda_oe_o), 0);
    pwdn = 1'b0; tick(10);
    read_cmp(idw, 8'h10, 3, "R11 registers kept");

    // Soft reset
    base = srst_cnt;
    wbuf[0] = 8'h80;
    do_write(idw, 8'h12, 1, acks);
    chk(acks == 3, "R10 soft reset write acked", acks, 3);
    tick(HOLD + 4);
    chk(srst_cnt - base == HOLD, "R10 core reset hold length", srst_cnt - base, HOLD);
    model_clear();
    do_write(idw, 8'h10, 1, acks);
    chk(acks == 0, "R10 straps recaptured, old id dead", acks, 0);
    read_cmp(id_byte(1'b1, 3'd3), 8'h10, 3, "R10 registers cleared");
    read_cmp(id_byte(1'b1, 3'd3), 8'h12, 1, "R10 bit self-cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end
endmodule